// File: doc/BRIEF.md
# Dual-Port Memory with Collision Busy Arbitration

This block is a synchronous two-ported byte memory. A left and a right port each carry a select, a write strobe, an address and a byte of write and read data. Either port may reach any location on any cycle. An arbiter watches for both selected ports pointing at the same location. When they do, it names one port the owner of the location and raises a busy flag toward the other. The busy flag suppresses that port's write while still letting it read. The arbiter is a three-state machine. `ARB_FREE` means there is no collision. `ARB_LEFT_HOLDS` means the left port owns the contested location and the right port is busy. `ARB_RIGHT_HOLDS` is the mirror case.

A port counts as *settled* when it was selected on the previous cycle at the same address. A port that became selected, or changed address, this cycle counts as an arrival. On a collision, the settled port wins over the arriving one. If both arrive together, the left port wins. A collision that continues unchanged keeps its owner. The transitions are:
- `ARB_FREE` to either HOLDS state when a match appears.
- HOLDS to HOLDS, the same or the other state, while a match persists.
- Any HOLDS state back to `ARB_FREE` when the match ends.

A mode pin selects master or slave behaviour. In master mode the busy outputs carry the arbiter's decision. In slave mode the arbiter's decision gates nothing. The busy outputs are held low, and each port's busy input blocks that port's writes. Several devices can then share one master's busy signals and form a wider word.

The address width defaults to 11 bits, giving 2048 locations. Setting `ADDR_W` to 14 gives 16384 locations.

Top module: `dpram_arb_top`

## Requirements
- R1: A selected port with its write strobe high stores its write byte at its address on the clock edge. A selected port presents the byte stored at its address on its read output after that edge. A read in the same cycle as a write to the same location returns the old byte.
- R2: While a port's select is low, its read output keeps its last value.
- R3: In master mode, suppose one port was selected at an address on the previous cycle and stays there. If the other port arrives at that same address, by raising its select or by changing its address, the arriving port's busy output goes high in that cycle and the settled port's stays low. This holds for either side.
- R4: In master mode, if both ports arrive at the same address in the same cycle, the right busy output goes high and the left stays low.
- R5: A busy output stays high while the collision continues with unchanged addresses and selects. It is low in any cycle in which either select is low or the addresses differ.
- R6: In master mode, a port whose busy output is high does not write, and the other port's write takes effect. Both ports read the stored byte. A port may write normally once its busy has dropped.
- R7: The two busy outputs are never high together.
- R8: With the mode pin low (slave), both busy outputs are low and a high busy input blocks that port's write. With the mode pin high (master), the busy inputs have no effect.
- R9: In slave mode, when both ports write the same location in one cycle and neither busy input is high, the left port's byte is stored.
- R10: After reset, both read outputs are 0 and both busy outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| master_i | input | 1 | 1 = master (busy driven), 0 = slave (busy sampled) |
| cs_l_i | input | 1 | Left port select |
| we_l_i | input | 1 | Left port write strobe |
| addr_l_i | input | ADDR_W | Left port address |
| wdata_l_i | input | DATA_W | Left port write byte |
| rdata_l_o | output | DATA_W | Left port read byte, registered |
| busy_l_i | input | 1 | Left write inhibit in slave mode |
| busy_l_o | output | 1 | Left busy flag in master mode, low in slave mode |
| cs_r_i | input | 1 | Right port select |
| we_r_i | input | 1 | Right port write strobe |
| addr_r_i | input | ADDR_W | Right port address |
| wdata_r_i | input | DATA_W | Right port write byte |
| rdata_r_o | output | DATA_W | Right port read byte, registered |
| busy_r_i | input | 1 | Right write inhibit in slave mode |
| busy_r_o | output | 1 | Right busy flag in master mode, low in slave mode |

## Verification
If the arbiter state held the wrong owner, the port that should keep the location would see its busy output rise within the collision cycle. The byte read back on the following cycle would then carry the loser's data. A stale settled flag in a port tracker shows up as a reversed winner on the very first cycle of a collision. The directed scenarios separate the two ways a collision can start, which would otherwise hide the fault. A fault in the release path keeps busy high during the cycle the match ends, so the release write is lost and its read-back one cycle later shows the old byte.

// File: rtl/dpram_arb_pkg.sv
package dpram_arb_pkg;

    // Owner of a contested location; the other side is busy.
    typedef enum logic [1:0] {
        ARB_FREE        = 2'd0,
        ARB_LEFT_HOLDS  = 2'd1,
        ARB_RIGHT_HOLDS = 2'd2
    } arb_state_e;

    localparam int unsigned PORT_CNT = 2;
    localparam int unsigned PORT_L   = 0;
    localparam int unsigned PORT_R   = 1;

endpackage

// File: rtl/dpram_port_track.sv
module dpram_port_track #(
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic [ADDR_W-1:0] addr,
    output logic              settled
);

    logic              cs_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q   <= 1'b0;
            addr_q <= '0;
        end else begin
            cs_q   <= cs;
            addr_q <= addr;
        end
    end

    // Selected last cycle at the very same address: not an arrival.
    always_comb settled = cs_q && cs && (addr_q == addr);

endmodule

// File: rtl/dpram_arb_fsm.sv
module dpram_arb_fsm
    import dpram_arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic match,
    input  logic settled_l,
    input  logic settled_r,
    output logic loser_l,
    output logic loser_r
);

    arb_state_e state_q;
    arb_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ARB_FREE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_FREE: begin
                if (match) begin
                    if (settled_r && !settled_l) state_d = ARB_RIGHT_HOLDS;
                    else                         state_d = ARB_LEFT_HOLDS;
                end
            end
            ARB_LEFT_HOLDS: begin
                if (!match)                       state_d = ARB_FREE;
                else if (settled_r && !settled_l) state_d = ARB_RIGHT_HOLDS;
                else                              state_d = ARB_LEFT_HOLDS;
            end
            ARB_RIGHT_HOLDS: begin
                if (!match)                         state_d = ARB_FREE;
                else if (settled_l && !settled_r)   state_d = ARB_LEFT_HOLDS;
                else if (!settled_l && !settled_r)  state_d = ARB_LEFT_HOLDS;
                else                                state_d = ARB_RIGHT_HOLDS;
            end
            default: state_d = ARB_FREE;
        endcase
    end

    // Decision applies in the same cycle so the loser's write is caught.
    always_comb begin
        loser_r = (state_d == ARB_LEFT_HOLDS);
        loser_l = (state_d == ARB_RIGHT_HOLDS);
    end

    assert_state_legal_R7: assert property (@(posedge clk) disable iff (rst)
        state_q inside {ARB_FREE, ARB_LEFT_HOLDS, ARB_RIGHT_HOLDS});

    assert_free_without_match_R5: assert property (@(posedge clk) disable iff (rst)
        !$past(match) |-> (state_q == ARB_FREE));

endmodule

// File: rtl/dpram_store.sv
module dpram_store #(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_l,
    input  logic              wen_l,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic [DATA_W-1:0] wdata_l,
    output logic [DATA_W-1:0] rdata_l,
    input  logic              cs_r,
    input  logic              wen_r,
    input  logic [ADDR_W-1:0] addr_r,
    input  logic [DATA_W-1:0] wdata_r,
    output logic [DATA_W-1:0] rdata_r
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Right first, left last: left wins a same-location double write.
    always_ff @(posedge clk) begin
        if (wen_r) mem[addr_r] <= wdata_r;
        if (wen_l) mem[addr_l] <= wdata_l;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_l <= '0;
            rdata_r <= '0;
        end else begin
            if (cs_l) rdata_l <= mem[addr_l];
            if (cs_r) rdata_r <= mem[addr_r];
        end
    end

    assert_left_read_holds_R2: assert property (@(posedge clk) disable iff (rst)
        !cs_l |=> $stable(rdata_l));

    assert_right_read_holds_R2: assert property (@(posedge clk) disable iff (rst)
        !cs_r |=> $stable(rdata_r));

endmodule

// File: rtl/dpram_arb_top.sv
module dpram_arb_top
    import dpram_arb_pkg::*;
#(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              master_i,
    input  logic              cs_l_i,
    input  logic              we_l_i,
    input  logic [ADDR_W-1:0] addr_l_i,
    input  logic [DATA_W-1:0] wdata_l_i,
    output logic [DATA_W-1:0] rdata_l_o,
    input  logic              busy_l_i,
    output logic              busy_l_o,
    input  logic              cs_r_i,
    input  logic              we_r_i,
    input  logic [ADDR_W-1:0] addr_r_i,
    input  logic [DATA_W-1:0] wdata_r_i,
    output logic [DATA_W-1:0] rdata_r_o,
    input  logic              busy_r_i,
    output logic              busy_r_o
);

    logic              cs_v      [PORT_CNT];
    logic [ADDR_W-1:0] addr_v    [PORT_CNT];
    logic              settled_v [PORT_CNT];

    always_comb begin
        cs_v[PORT_L]   = cs_l_i;
        cs_v[PORT_R]   = cs_r_i;
        addr_v[PORT_L] = addr_l_i;
        addr_v[PORT_R] = addr_r_i;
    end

    for (genvar p = 0; p < PORT_CNT; p++) begin : g_track
        dpram_port_track #(.ADDR_W(ADDR_W)) u_track (
            .clk     (clk),
            .rst     (rst),
            .cs      (cs_v[p]),
            .addr    (addr_v[p]),
            .settled (settled_v[p])
        );
    end

    logic match;
    logic loser_l, loser_r;
    logic inhibit_l, inhibit_r;
    logic wen_l, wen_r;

    always_comb match = cs_l_i && cs_r_i && (addr_l_i == addr_r_i);

    dpram_arb_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .match     (match),
        .settled_l (settled_v[PORT_L]),
        .settled_r (settled_v[PORT_R]),
        .loser_l   (loser_l),
        .loser_r   (loser_r)
    );

    always_comb begin
        inhibit_l = master_i ? loser_l : busy_l_i;
        inhibit_r = master_i ? loser_r : busy_r_i;
        wen_l     = cs_l_i && we_l_i && !inhibit_l;
        wen_r     = cs_r_i && we_r_i && !inhibit_r;
        busy_l_o  = master_i && loser_l;
        busy_r_o  = master_i && loser_r;
    end

    dpram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .cs_l    (cs_l_i),
        .wen_l   (wen_l),
        .addr_l  (addr_l_i),
        .wdata_l (wdata_l_i),
        .rdata_l (rdata_l_o),
        .cs_r    (cs_r_i),
        .wen_r   (wen_r),
        .addr_r  (addr_r_i),
        .wdata_r (wdata_r_i),
        .rdata_r (rdata_r_o)
    );

    assert_single_busy_R7: assert property (@(posedge clk) disable iff (rst)
        !(busy_l_o && busy_r_o));

    assert_busy_needs_match_R5: assert property (@(posedge clk) disable iff (rst)
        (busy_l_o || busy_r_o) |-> (cs_l_i && cs_r_i && (addr_l_i == addr_r_i)));

    assert_slave_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !master_i |-> (!busy_l_o && !busy_r_o));

    assert_busy_sticks_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(busy_r_o) && $past(cs_l_i) && $past(cs_r_i) &&
         cs_l_i && cs_r_i && master_i && $stable(addr_l_i) && $stable(addr_r_i))
        |-> busy_r_o);

    assert_busy_no_write_R6: assert property (@(posedge clk) disable iff (rst)
        busy_l_o |-> !wen_l);

endmodule

// File: tb/dpram_arb_top_tb.sv
`timescale 1ns/1ps
module dpram_arb_top_tb;

    localparam int unsigned AW = 11;
    localparam int unsigned DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          master_i = 1'b1;
    logic          cs_l_i = 1'b0, we_l_i = 1'b0, busy_l_i = 1'b0;
    logic          cs_r_i = 1'b0, we_r_i = 1'b0, busy_r_i = 1'b0;
    logic [AW-1:0] addr_l_i = '0, addr_r_i = '0;
    logic [DW-1:0] wdata_l_i = '0, wdata_r_i = '0;
    logic [DW-1:0] rdata_l_o, rdata_r_o;
    logic          busy_l_o, busy_r_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dpram_arb_top #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .master_i(master_i),
        .cs_l_i(cs_l_i), .we_l_i(we_l_i), .addr_l_i(addr_l_i),
        .wdata_l_i(wdata_l_i), .rdata_l_o(rdata_l_o),
        .busy_l_i(busy_l_i), .busy_l_o(busy_l_o),
        .cs_r_i(cs_r_i), .we_r_i(we_r_i), .addr_r_i(addr_r_i),
        .wdata_r_i(wdata_r_i), .rdata_r_o(rdata_r_o),
        .busy_r_i(busy_r_i), .busy_r_o(busy_r_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_l(input logic cs, input logic we, input int a, input logic [7:0] d);
        cs_l_i = cs; we_l_i = we; addr_l_i = AW'(a); wdata_l_i = d;
    endtask

    task automatic set_r(input logic cs, input logic we, input int a, input logic [7:0] d);
        cs_r_i = cs; we_r_i = we; addr_r_i = AW'(a); wdata_r_i = d;
    endtask

    task automatic t_reset();
        chk("R10 rdata_l after reset", rdata_l_o, 8'h00);
        chk("R10 rdata_r after reset", rdata_r_o, 8'h00);
        chk("R10 busy_l after reset", {7'd0, busy_l_o}, 8'h00);
        chk("R10 busy_r after reset", {7'd0, busy_r_o}, 8'h00);
    endtask

    task automatic t_basic();
        set_l(1, 1, 10, 8'hA5); set_r(0, 0, 0, 8'h00); step();
        set_l(1, 0, 10, 8'h00); step();
        chk("R1 left read after write", rdata_l_o, 8'hA5);
        set_l(1, 1, 10, 8'h3C); step();
        chk("R1 read-old during write", rdata_l_o, 8'hA5);
        set_l(0, 0, 10, 8'h00); step();
        chk("R2 left holds while deselected", rdata_l_o, 8'hA5);
        set_r(1, 0, 10, 8'h00); step();
        chk("R1 right reads left's write", rdata_r_o, 8'h3C);
        chk("R2 left still holds", rdata_l_o, 8'hA5);
        set_r(0, 0, 0, 8'h00); step();
    endtask

    task automatic t_left_settled();
        set_l(1, 0, 20, 8'h00); set_r(1, 0, 21, 8'h00); #1;
        chk("R5 no busy for distinct addresses", {6'd0, busy_l_o, busy_r_o}, 8'h00);
        step();
        set_l(1, 1, 20, 8'h11); set_r(1, 1, 20, 8'h77); #1;
        chk("R3 arriving right is busy", {7'd0, busy_r_o}, 8'h01);
        chk("R3 settled left not busy", {7'd0, busy_l_o}, 8'h00);
        step();
        set_l(1, 0, 20, 8'h00); set_r(1, 0, 20, 8'h00); #1;
        chk("R5 busy holds during collision", {7'd0, busy_r_o}, 8'h01);
        step();
        chk("R6 winner's byte read on left", rdata_l_o, 8'h11);
        chk("R6 busy right reads stored byte", rdata_r_o, 8'h11);
        set_r(0, 0, 20, 8'h00); #1;
        chk("R5 busy drops with select", {7'd0, busy_r_o}, 8'h00);
        step();
    endtask

    task automatic t_right_settled();
        set_r(1, 0, 30, 8'h00); set_l(0, 0, 30, 8'h00); step();
        set_l(1, 1, 30, 8'h99); set_r(1, 1, 30, 8'h55); #1;
        chk("R3 arriving left is busy", {7'd0, busy_l_o}, 8'h01);
        chk("R3 settled right not busy", {7'd0, busy_r_o}, 8'h00);
        step();
        set_l(1, 0, 30, 8'h00); set_r(1, 0, 30, 8'h00); step();
        chk("R6 left write blocked", rdata_l_o, 8'h55);
        chk("R6 right write landed", rdata_r_o, 8'h55);
        set_l(1, 0, 31, 8'h00); #1;
        chk("R5 busy drops on address change", {7'd0, busy_l_o}, 8'h00);
        step();
    endtask

    task automatic t_tie();
        set_l(0, 0, 0, 8'h00); set_r(0, 0, 0, 8'h00); step();
        set_l(1, 1, 40, 8'h12); set_r(1, 1, 40, 8'h34); #1;
        chk("R4 tie: right busy", {7'd0, busy_r_o}, 8'h01);
        chk("R7 tie: left not busy", {7'd0, busy_l_o}, 8'h00);
        step();
        set_l(1, 0, 40, 8'h00); set_r(1, 0, 40, 8'h00); #1;
        chk("R5 tie owner kept", {6'd0, busy_l_o, busy_r_o}, 8'h01);
        step();
        chk("R4 left byte stored on tie", rdata_l_o, 8'h12);
        set_l(1, 0, 41, 8'h00); set_r(1, 1, 40, 8'h56); #1;
        chk("R6 right free after release", {7'd0, busy_r_o}, 8'h00);
        step();
        set_r(1, 0, 40, 8'h00); step();
        chk("R6 write after release lands", rdata_r_o, 8'h56);
        set_l(0, 0, 0, 8'h00); set_r(0, 0, 0, 8'h00); step();
    endtask

    task automatic t_slave();
        master_i = 1'b0;
        set_l(1, 1, 50, 8'hAA); set_r(1, 1, 50, 8'hBB); #1;
        chk("R8 slave busy outputs low", {6'd0, busy_l_o, busy_r_o}, 8'h00);
        step();
        set_l(1, 0, 50, 8'h00); set_r(0, 0, 0, 8'h00); step();
        chk("R9 left byte wins double write", rdata_l_o, 8'hAA);
        set_l(1, 1, 60, 8'h01); set_r(1, 1, 61, 8'h02); step();
        busy_r_i = 1'b1; busy_l_i = 1'b1;
        set_l(1, 1, 61, 8'hFF); set_r(1, 1, 60, 8'hCC); step();
        busy_r_i = 1'b0; busy_l_i = 1'b0;
        set_l(1, 0, 60, 8'h00); set_r(1, 0, 61, 8'h00); step();
        chk("R8 right write inhibited by busy input", rdata_l_o, 8'h01);
        chk("R8 left write inhibited by busy input", rdata_r_o, 8'h02);
        master_i = 1'b1; busy_l_i = 1'b1;
        set_l(1, 1, 70, 8'h7E); set_r(0, 0, 0, 8'h00); step();
        busy_l_i = 1'b0;
        set_l(1, 0, 70, 8'h00); step();
        chk("R8 busy input ignored in master mode", rdata_l_o, 8'h7E);
        set_l(0, 0, 0, 8'h00); step();
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step();
        t_reset();
        t_basic();
        t_left_settled();
        t_right_settled();
        t_tie();
        t_slave();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule